// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a free-running watchdog counter that asks for a system reset unless software services it in time. Servicing is a two-step handshake, and both steps are written to the same service register. An arming key must be written first. A later write of the clearing key then restarts the count. Any amount of unrelated bus traffic may fall between the two writes. If a clearing write arrives with no arming write before it, nothing happens.

A 2-bit rate select picks one of four timeout lengths: 2^15, 2^17, 2^19 or 2^21 clock cycles. Each length is divided by 2^`SCALE_SHIFT` so that simulation runs stay short. An enable input stands in for a running clock. While the enable is low the count is frozen, as it would be if the clock were stopped. On timeout the block raises a one-cycle request pulse, which feeds the system reset generator.

Top module: `key_watchdog`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wdg_rst_req` is low. The count is zero and the block is unarmed.
- R2: With `wdg_en` held high and no service, `wdg_rst_req` goes high on exactly the Nth rising edge after the count was last zeroed. N depends on `rate_sel`: 0 gives 2^(15-SCALE_SHIFT), 1 gives 2^(17-SCALE_SHIFT), 2 gives 2^(19-SCALE_SHIFT) and 3 gives 2^(21-SCALE_SHIFT).
- R3: `wdg_rst_req` is high for a single cycle. The count restarts from zero on that same edge, so the next request comes N cycles later.
- R4: A write (`bus_we` high) of 0x55 to address `SVC_ADDR` (default 0x3A) arms the block. It does not change the count.
- R5: A write of 0xAA to `SVC_ADDR` while armed sets the count to zero and disarms the block. The next service therefore needs a new 0x55.
- R6: A write of 0xAA to `SVC_ADDR` while unarmed has no effect on the count or on the armed state.
- R7: Writes of any other value to `SVC_ADDR`, and all writes to other addresses, leave the armed state and the count unchanged. This holds for any number of such writes.
- R8: While `wdg_en` is low, the count holds and no request is raised. Key writes are still processed during this time.
- R9: A clearing write that lands on the edge that would have timed out takes priority. No request is raised and the count restarts from zero.
- R10: A change of `rate_sel` takes effect at once. If the count already stands at or past the new limit minus one, the request comes on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdg_en | input | 1 | Watchdog run enable; low freezes the count |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| rate_sel | input | 2 | Timeout length select |
| wdg_rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench checks the following corner cases. Each note says what a faulty design would do.
- A clearing key sent to an unarmed block. A design that skips the arming check would accept this write as a valid service.
- A second clearing key sent right after a successful service. A design that forgets to disarm would accept it too, and the next request would come late.
- Stray values and writes to other addresses between the two keys. A design that drops the armed state on such traffic would miss the later clear and raise the request too early.
- A clear that lands exactly on the timeout edge. A design with the wrong priority would raise a request even though software serviced the watchdog in time.
- Frozen periods and rate switches to a shorter timeout. These expose designs that keep counting while disabled, and designs that compare for equality and run past the new limit.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int unsigned KEY_W      = 8;
    localparam int unsigned RATE_W     = 2;
    localparam int unsigned NUM_RATES  = 1 << RATE_W;
    localparam int unsigned BASE_LOG2  = 15;
    localparam int unsigned STEP_LOG2  = 2;
    localparam int unsigned MAX_LOG2   = BASE_LOG2 + STEP_LOG2 * (NUM_RATES - 1);

    localparam logic [KEY_W-1:0] ARM_KEY   = 8'h55;
    localparam logic [KEY_W-1:0] CLEAR_KEY = 8'hAA;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_t;

    // decoded view of one bus cycle at the service register
    typedef struct packed {
        logic arm;
        logic clear;
        logic other;
    } svc_evt_t;

    // count width needed for the longest scaled timeout
    function automatic int unsigned cnt_width(input int unsigned shift);
        return MAX_LOG2 - shift + 1;
    endfunction

    // terminal count (limit - 1) for a rate index, as 32 bits
    function automatic logic [31:0] rate_term(input int unsigned rate,
                                              input int unsigned shift);
        logic [31:0] one;
        one = 32'd1;
        return (one << (BASE_LOG2 + STEP_LOG2 * rate - shift)) - 32'd1;
    endfunction

endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic              armed,
    output logic              clr_pulse
);

    svc_evt_t   evt;
    key_state_t state_q, state_d;
    logic       hit;

    assign hit = bus_we && (bus_addr == SVC_ADDR);

    always_comb begin
        evt       = '0;
        evt.arm   = hit && (bus_wdata == ARM_KEY);
        evt.clear = hit && (bus_wdata == CLEAR_KEY);
        evt.other = hit && !evt.arm && !evt.clear;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE: begin
                if (evt.arm) state_d = KS_ARMED;
            end
            KS_ARMED: begin
                if (evt.clear) state_d = KS_IDLE;
            end
            default: state_d = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_IDLE;
        else     state_q <= state_d;
    end

    assign armed     = (state_q == KS_ARMED);
    assign clr_pulse = armed && evt.clear;

endmodule

// File: rtl/kwd_rate_sel.sv
module kwd_rate_sel
    import kwd_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 10,
    parameter int unsigned CNT_W = cnt_width(SCALE_SHIFT)
) (
    input  logic [RATE_W-1:0] rate_sel,
    output logic [CNT_W-1:0]  term
);

    logic [CNT_W-1:0] term_tab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam logic [31:0] TERM32 = rate_term(g, SCALE_SHIFT);
        assign term_tab[g] = TERM32[CNT_W-1:0];
    end

    assign term = term_tab[rate_sel];

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             at_term;

    // >= so that a switch to a shorter rate cannot overrun the limit
    assign at_term = (cnt_q >= term);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (run) begin
                if (at_term) begin
                    cnt_q <= '0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt    = cnt_q;
    assign expire = exp_q;

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h3A,
    parameter int unsigned SCALE_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wdg_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [1:0]        rate_sel,
    output logic              wdg_rst_req
);

    localparam int unsigned CNT_W = cnt_width(SCALE_SHIFT);

    logic             armed;
    logic             clr_pulse;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt;

    kwd_key_seq #(
        .ADDR_W   (ADDR_W),
        .SVC_ADDR (SVC_ADDR)
    ) u_key (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .armed     (armed),
        .clr_pulse (clr_pulse)
    );

    kwd_rate_sel #(
        .SCALE_SHIFT (SCALE_SHIFT),
        .CNT_W       (CNT_W)
    ) u_rate (
        .rate_sel (rate_sel),
        .term     (term)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (wdg_en),
        .clr    (clr_pulse),
        .term   (term),
        .cnt    (cnt),
        .expire (wdg_rst_req)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h3A,
    parameter int unsigned CNT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wdg_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              wdg_rst_req,
    input logic              armed,
    input logic              clr_pulse,
    input logic [CNT_W-1:0]  cnt
);

    logic svc_wr;
    assign svc_wr = bus_we && (bus_addr == SVC_ADDR);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!wdg_rst_req && !armed && (cnt == '0))); // R1

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_req |=> !wdg_rst_req); // R3

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_req |-> (cnt == '0)); // R3

    AST_ARM_KEY: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && bus_wdata == 8'h55) |=> armed); // R4

    AST_CLEAR_KEY: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && bus_wdata == 8'hAA && armed) |=> (!armed && cnt == '0)); // R5

    AST_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && bus_wdata == 8'hAA && !armed) |=> !armed); // R6

    AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!(svc_wr && (bus_wdata == 8'h55 || bus_wdata == 8'hAA))) |=> (armed == $past(armed))); // R7

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wdg_en && !clr_pulse) |=> $stable(cnt)); // R8

    AST_FROZEN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !wdg_en |=> !wdg_rst_req); // R8

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !wdg_rst_req); // R9

endmodule

bind key_watchdog kwd_checker #(
    .ADDR_W   (ADDR_W),
    .SVC_ADDR (SVC_ADDR),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wdg_en      (wdg_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wdg_rst_req (wdg_rst_req),
    .armed       (armed),
    .clr_pulse   (clr_pulse),
    .cnt         (cnt)
);

// File: tb/sim_key_watchdog.sv
`timescale 1ns/1ps
module sim_key_watchdog;

    localparam int SHIFT = 10;
    localparam logic [7:0] SVC = 8'h3A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wdg_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [1:0] rate_sel = 2'd0;
    logic       wdg_rst_req;

    int n_chk = 0;
    int n_bad = 0;

    // bench reference state
    int m_cnt = 0;
    bit m_armed = 1'b0;
    bit m_req = 1'b0;

    always #5 clk = ~clk;

    key_watchdog #(.SCALE_SHIFT(SHIFT)) u0 (
        .clk         (clk),
        .rst         (rst),
        .wdg_en      (wdg_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .rate_sel    (rate_sel),
        .wdg_rst_req (wdg_rst_req)
    );

    function automatic int lim(input logic [1:0] r);
        return 1 << (15 + 2 * int'(r) - SHIFT);
    endfunction

    task automatic check(input string tag, input bit got, input bit exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: wdg_rst_req actual=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                        input bit en, input logic [1:0] r, input string tag);
        bit hit, clr;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; wdg_en = en; rate_sel = r;
        hit = we && (a == SVC);
        clr = hit && (d == 8'hAA) && m_armed;
        m_req = 1'b0;
        if (clr) m_cnt = 0;
        else if (en) begin
            if (m_cnt >= lim(r) - 1) begin m_cnt = 0; m_req = 1'b1; end
            else m_cnt++;
        end
        if (hit && d == 8'h55) m_armed = 1'b1;
        else if (clr) m_armed = 1'b0;
        @(posedge clk);
        #1;
        check(tag, wdg_rst_req, m_req);
    endtask

    task automatic idle(input int n, input logic [1:0] r, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b1, r, tag);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1", wdg_rst_req, 1'b0);
        end
        @(negedge clk); rst = 1'b0;

        // R6: clear key while unarmed, then timeout still lands at 32 (R2)
        step(1'b1, SVC, 8'hAA, 1'b1, 2'd0, "R6");
        idle(40, 2'd0, "R2");
        idle(40, 2'd0, "R3");

        // R4/R7/R5: arm, stray traffic, clear
        step(1'b1, SVC, 8'h55, 1'b1, 2'd0, "R4");
        step(1'b1, 8'h3B, 8'hAA, 1'b1, 2'd0, "R7");
        step(1'b1, 8'h10, 8'h55, 1'b1, 2'd0, "R7");
        step(1'b1, SVC, 8'h13, 1'b1, 2'd0, "R7");
        step(1'b0, SVC, 8'hAA, 1'b1, 2'd0, "R7");
        idle(5, 2'd0, "R7");
        step(1'b1, SVC, 8'hAA, 1'b1, 2'd0, "R5");
        step(1'b1, SVC, 8'hAA, 1'b1, 2'd0, "R5");
        idle(70, 2'd0, "R5");

        // R8: frozen, keys still processed
        idle(10, 2'd0, "R8");
        for (int i = 0; i < 60; i++)
            step((i == 20), SVC, 8'h55, 1'b0, 2'd0, "R8");
        step(1'b1, SVC, 8'hAA, 1'b0, 2'd0, "R8");
        idle(40, 2'd0, "R8");

        // R9: clear on the timeout edge
        step(1'b1, SVC, 8'h55, 1'b1, 2'd0, "R9");
        while (m_cnt != lim(2'd0) - 1) idle(1, 2'd0, "R9");
        step(1'b1, SVC, 8'hAA, 1'b1, 2'd0, "R9");
        idle(40, 2'd0, "R9");

        // R10: shorten the rate mid-count
        step(1'b1, SVC, 8'h55, 1'b1, 2'd3, "R10");
        step(1'b1, SVC, 8'hAA, 1'b1, 2'd3, "R10");
        idle(100, 2'd3, "R10");
        idle(40, 2'd0, "R10");
        idle(2100, 2'd3, "R2");
        idle(600, 2'd2, "R2");
        idle(300, 2'd1, "R2");

        // random traffic
        begin
            logic [1:0] r = 2'd0;
            for (int i = 0; i < 40000; i++) begin
                int k;
                bit we, en;
                logic [7:0] a, d;
                if (($urandom % 2000) == 0) r = 2'($urandom);
                k  = int'($urandom % 16);
                we = (k < 5);
                a  = (k < 3) ? SVC : 8'($urandom);
                d  = (k == 0) ? 8'h55 : (k == 1) ? 8'hAA : 8'($urandom);
                en = ($urandom % 10) != 0;
                step(we, a, d, en, r, "R7");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule